// File: doc/BRIEF.md
# Programmable CIC Decimator

This block is a cascaded integrator-comb decimation filter for signed 16-bit fractional samples. It turns a fast input stream into a slower one. The number of active stages can be set from one to five, and the decimation ratio can be set from 1 to 1024. First a programmable arithmetic right shift scales each accepted sample down by the bit growth the filter will add. The sample then runs through the integrator chain at the input rate. A rate divider picks every D-th accepted sample into a decimation register. That value feeds the comb chain. The comb result is rounded symmetrically to 16 integer bits and 3 fraction bits and saturated.

All settings arrive as static ports. They may change only while reset is held. After reset the block ignores its input until a start pulse arrives. From then on it runs until the next reset. In bypass mode the filter reduces to a pure delay: every accepted sample leaves unscaled, with three fraction bits of zero appended.

Top module: `cic_decimator`

## Requirements
- R1: While `rstN` is low, and after its release until a start pulse has been seen, `outValid` is 0 and `outData` is 0.
- R2: Samples presented with `inValid` high before the start pulse leave no trace in any later output.
- R3: `cfgRate` holds D-1. Exactly one output is produced for every D accepted samples, where a sample counts as accepted when `inValid` is high after start. The first output belongs to accepted sample D-1, counted from 0. `outValid` rises two clock cycles after the cycle in which that sample was presented.
- R4: Output k equals the N-stage CIC response, that is N-fold running sums followed by N first differences at the decimated rate. It is taken over accepted samples 0 to kD+D-6, with earlier samples taken as zero, and scaled by 2^-growth.
- R5: `cfgStages` holds N. The value 0 disables all stages and leaves a plain delayed decimator. The values 5, 6 and 7 all give five stages. A disabled integrator adds nothing to its input, and a disabled comb subtracts nothing from its input.
- R6: `cfgGrowth` (0 to 50) sets a right shift of the input before integration. It scales the output by 2^-cfgGrowth, and the full precision of the filter is kept.
- R7: `outData` is two's complement with 3 fraction bits, equal to round(8·y). Ties are rounded away from zero, so +x and -x always give outputs of equal magnitude.
- R8: A rounded value above 262143 is clamped to 262143 (0x3FFFF). A value below -262144 is clamped to -262144. The output never wraps.
- R9: With `cfgBypass` high, the ratio, stage and growth settings are ignored. Every accepted sample n produces an output equal to 8·x[n-5], with x[negative] = 0.
- R10: Clock cycles with `inValid` low do not advance the filter or the divider. `outData` changes only in a cycle where `outValid` is high. With D of 2 or more, `outValid` is never high in two consecutive cycles.
- R11: `rstN` is active-low and asynchronous. It clears all filter state and the divider and stops the block. The block runs again only after a new start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse; the block runs from the following cycle |
| inValid | input | 1 | Marks `inData` as a sample in this cycle |
| inData | input | 16 | Signed fractional input sample |
| cfgRate | input | 10 | Decimation ratio minus one |
| cfgStages | input | 3 | Number of active stages |
| cfgGrowth | input | 6 | Input right-shift amount |
| cfgBypass | input | 1 | Pass input through unfiltered |
| outValid | output | 1 | One-cycle strobe for a new decimated sample |
| outData | output | 19 | Rounded output, 16 integer and 3 fraction bits |

## Verification
The hardest condition to reach from the ports is saturation. With a correctly programmed growth the filter gain never exceeds one, so the rounder can only overflow when the true output lies within half an output step below full scale. The bench reaches it deliberately with one stage, D = 33 and a growth of 5 instead of 6. A constant input of 31775 then settles at 32767.96875, which rounds up past the top of the range. The negated input lands exactly on the most negative code, which checks symmetry at the same point. The other scenarios compare every output against an integer model of running sums and differences. The mixes include gapped `inValid`, stage codes of 0 and 7, and input seen before start.

// File: rtl/cic_pkg.sv
package cic_pkg;

  // Strobes handed from the sequencing logic to the arithmetic
  typedef struct packed {
    logic sampleEn;  // accepted input sample this cycle
    logic decEn;     // accepted sample is a decimation point
    logic combEn;    // comb chain and output register advance
  } cicStrobes_t;

endpackage

// File: rtl/cic_ctrl.sv
module cic_ctrl
  import cic_pkg::*;
#(
  parameter int STAGES = 5,
  parameter int RATE_W = 10,
  parameter int GROW_W = 6,
  parameter int STG_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              inValid,
  input  logic [RATE_W-1:0] cfgRate,
  input  logic [STG_W-1:0]  cfgStages,
  input  logic [GROW_W-1:0] cfgGrowth,
  input  logic              cfgBypass,
  output cicStrobes_t       strb,
  output logic [STAGES-1:0] stageEn,
  output logic [GROW_W-1:0] shiftAmt
);

  logic              running;
  logic [RATE_W-1:0] rateCnt;
  logic [RATE_W-1:0] effRate;
  logic              sampleEn;
  logic              lastSample;
  logic              combEnQ;

  always_comb begin
    effRate    = cfgBypass ? '0 : cfgRate;
    sampleEn   = running & inValid;
    lastSample = sampleEn && (rateCnt == effRate);
    shiftAmt   = cfgBypass ? '0 : cfgGrowth;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      rateCnt <= '0;
      combEnQ <= 1'b0;
    end else begin
      running <= running | start;
      combEnQ <= lastSample;
      if (sampleEn) begin
        rateCnt <= lastSample ? '0 : rateCnt + 1'b1;
      end
    end
  end

  // Stage k is active when k < cfgStages; codes above STAGES saturate
  for (genvar k = 0; k < STAGES; k++) begin : g_stageDecode
    assign stageEn[k] = ~cfgBypass & (STG_W'(k) < cfgStages);
  end

  assign strb.sampleEn = sampleEn;
  assign strb.decEn    = lastSample;
  assign strb.combEn   = combEnQ;

endmodule

// File: rtl/cic_rounder.sv
module cic_rounder #(
  parameter int ACC_W = 66,
  parameter int OUT_W = 19
) (
  input  logic signed [ACC_W-1:0] val,
  output logic        [OUT_W-1:0] q
);

  localparam int DROP = ACC_W - OUT_W;
  localparam logic [ACC_W:0] HALF = {{(ACC_W + 1 - DROP){1'b0}}, 1'b1, {(DROP - 1){1'b0}}};
  localparam logic [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W - 1){1'b1}}};
  localparam logic [OUT_W-1:0] NEG_MIN = {1'b1, {(OUT_W - 1){1'b0}}};

  logic signed [ACC_W:0] wide;
  logic signed [ACC_W:0] biased;
  logic signed [ACC_W:0] scaled;
  logic        [OUT_W:0] top;

  always_comb begin
    wide   = {val[ACC_W-1], val};
    // add half an output step, one less for negatives: ties go away from zero
    biased = wide + $signed(HALF) - $signed({{ACC_W{1'b0}}, val[ACC_W-1]});
    scaled = biased >>> DROP;
    top    = scaled[OUT_W:0];
    if (top[OUT_W] != top[OUT_W-1]) begin
      q = top[OUT_W] ? NEG_MIN : POS_MAX;
    end else begin
      q = top[OUT_W-1:0];
    end
  end

endmodule

// File: rtl/cic_datapath.sv
module cic_datapath
  import cic_pkg::*;
#(
  parameter int IN_W   = 16,
  parameter int STAGES = 5,
  parameter int GROW_W = 6,
  parameter int ACC_W  = 66,
  parameter int OUT_W  = 19
) (
  input  logic              clk,
  input  logic              rstN,
  input  cicStrobes_t       strb,
  input  logic [STAGES-1:0] stageEn,
  input  logic [GROW_W-1:0] shiftAmt,
  input  logic [IN_W-1:0]   inData,
  output logic              outValid,
  output logic [OUT_W-1:0]  outData
);

  localparam int PAD = ACC_W - IN_W;

  logic signed [ACC_W-1:0] aligned;
  logic signed [ACC_W-1:0] intIn   [STAGES];
  logic signed [ACC_W-1:0] integ   [STAGES];
  logic signed [ACC_W-1:0] decReg;
  logic signed [ACC_W-1:0] combIn  [STAGES+1];
  logic signed [ACC_W-1:0] combDly [STAGES];
  logic        [OUT_W-1:0] rounded;

  assign aligned = $signed({inData, {PAD{1'b0}}}) >>> shiftAmt;

  // Integrators: each stage registered, all advance on an accepted sample
  for (genvar k = 0; k < STAGES; k++) begin : g_integ
    if (k == 0) begin : g_first
      assign intIn[k] = aligned;
    end else begin : g_next
      assign intIn[k] = integ[k-1];
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        integ[k] <= '0;
      end else if (strb.sampleEn) begin
        integ[k] <= (stageEn[k] ? integ[k] : '0) + intIn[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      decReg <= '0;
    end else if (strb.decEn) begin
      decReg <= integ[STAGES-1];
    end
  end

  // Combs: combinational subtract chain, delay registers on the slow strobe
  assign combIn[0] = decReg;
  for (genvar k = 0; k < STAGES; k++) begin : g_comb
    assign combIn[k+1] = combIn[k] - combDly[k];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        combDly[k] <= '0;
      end else if (strb.combEn) begin
        combDly[k] <= stageEn[k] ? combIn[k] : '0;
      end
    end
  end

  cic_rounder #(
    .ACC_W(ACC_W),
    .OUT_W(OUT_W)
  ) u_round (
    .val(combIn[STAGES]),
    .q  (rounded)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= strb.combEn;
      if (strb.combEn) begin
        outData <= rounded;
      end
    end
  end

endmodule

// File: rtl/cic_decimator.sv
module cic_decimator
  import cic_pkg::*;
#(
  parameter int IN_W   = 16,
  parameter int STAGES = 5,
  parameter int RATE_W = 10,
  parameter int GROW_W = 6,
  parameter int FRAC_W = 3,
  localparam int STG_W = $clog2(STAGES + 1),
  localparam int OUT_W = IN_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              inValid,
  input  logic [IN_W-1:0]   inData,
  input  logic [RATE_W-1:0] cfgRate,
  input  logic [STG_W-1:0]  cfgStages,
  input  logic [GROW_W-1:0] cfgGrowth,
  input  logic              cfgBypass,
  output logic              outValid,
  output logic [OUT_W-1:0]  outData
);

  // Full precision: room for the largest growth the ratio and stages allow
  localparam int ACC_W = IN_W + STAGES * RATE_W;

  cicStrobes_t       strb;
  logic [STAGES-1:0] stageEn;
  logic [GROW_W-1:0] shiftAmt;

  cic_ctrl #(
    .STAGES(STAGES),
    .RATE_W(RATE_W),
    .GROW_W(GROW_W),
    .STG_W (STG_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .inValid  (inValid),
    .cfgRate  (cfgRate),
    .cfgStages(cfgStages),
    .cfgGrowth(cfgGrowth),
    .cfgBypass(cfgBypass),
    .strb     (strb),
    .stageEn  (stageEn),
    .shiftAmt (shiftAmt)
  );

  cic_datapath #(
    .IN_W  (IN_W),
    .STAGES(STAGES),
    .GROW_W(GROW_W),
    .ACC_W (ACC_W),
    .OUT_W (OUT_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .stageEn (stageEn),
    .shiftAmt(shiftAmt),
    .inData  (inData),
    .outValid(outValid),
    .outData (outData)
  );

endmodule

// File: rtl/cic_decimator_chk.sv
module cic_decimator_chk #(
  parameter int RATE_W = 10,
  parameter int OUT_W  = 19
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              inValid,
  input logic [RATE_W-1:0] cfgRate,
  input logic              cfgBypass,
  input logic              outValid,
  input logic [OUT_W-1:0]  outData
);

  logic              started;
  logic [RATE_W-1:0] seen;
  logic              accepted;
  logic              wrapHit;

  assign accepted = started & inValid;
  assign wrapHit  = accepted && (seen == (cfgBypass ? '0 : cfgRate));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      started <= 1'b0;
      seen    <= '0;
    end else begin
      if (start) started <= 1'b1;
      if (accepted) seen <= wrapHit ? '0 : seen + 1'b1;
    end
  end

  // R1: nothing leaves the block before a start pulse
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !started |-> !outValid);

  // R3: every D-th accepted sample yields a strobe two cycles later
  a_r3_decimation_point: assert property (@(posedge clk) disable iff (!rstN)
    wrapHit |=> ##1 outValid);

  // R3: no strobe without a decimation point two cycles earlier
  a_r3_needs_sample: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(wrapHit, 2));

  // R9: in bypass every accepted sample produces an output
  a_r9_bypass_each: assert property (@(posedge clk) disable iff (!rstN)
    (cfgBypass && accepted) |=> ##1 outValid);

  // R10: output data moves only together with the strobe
  a_r10_hold_between: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(outData) |-> outValid);

endmodule

bind cic_decimator cic_decimator_chk #(
  .RATE_W(RATE_W),
  .OUT_W (OUT_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .inValid  (inValid),
  .cfgRate  (cfgRate),
  .cfgBypass(cfgBypass),
  .outValid (outValid),
  .outData  (outData)
);

// File: tb/cic_decimator_tb.sv
module cic_decimator_tb;

  localparam int MAXS = 400;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        inValid = 1'b0;
  logic [15:0] inData = '0;
  logic [9:0]  cfgRate = '0;
  logic [2:0]  cfgStages = '0;
  logic [5:0]  cfgGrowth = '0;
  logic        cfgBypass = 1'b0;
  logic        outValid;
  logic [18:0] outData;

  int checks = 0;
  int errors = 0;

  int          xs   [MAXS];
  longint      acc  [MAXS];
  longint      dk   [MAXS];
  logic [18:0] got  [MAXS];
  int          nGot = 0;
  logic        prevValid = 1'b0;
  int          backToBack = 0;
  int unsigned seed = 32'h1234_5678;

  always #2 clk = ~clk;

  cic_decimator u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .inValid  (inValid),
    .inData   (inData),
    .cfgRate  (cfgRate),
    .cfgStages(cfgStages),
    .cfgGrowth(cfgGrowth),
    .cfgBypass(cfgBypass),
    .outValid (outValid),
    .outData  (outData)
  );

  // Output collector, sampled away from the active edge
  always @(negedge clk) begin
    if (outValid && nGot < MAXS) begin
      got[nGot] = outData;
      nGot = nGot + 1;
    end
    if (outValid && prevValid) backToBack = backToBack + 1;
    prevValid = outValid;
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int nextRand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'(seed >> 8);
  endfunction

  // Symmetric rounding to 3 fraction bits, then clamp (R7, R8)
  function automatic longint roundModel(input longint v, input int g);
    longint mag, q;
    mag = (v < 0) ? -v : v;
    if (g <= 3) q = mag <<< (3 - g);
    else        q = (mag + (longint'(1) <<< (g - 4))) >>> (g - 3);
    if (v < 0) q = -q;
    if (q > 262143)  q = 262143;
    if (q < -262144) q = -262144;
    return q;
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    start = 1'b0;
    inValid = 1'b0;
    repeat (3) @(negedge clk);
    nGot = 0;
    backToBack = 0;
    rstN = 1'b1;
  endtask

  task automatic pulseStart();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic feed(input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      inValid = 1'b1;
      inData  = 16'(xs[i]);
      @(negedge clk);
      if (gaps) begin
        inValid = 1'b0;
        inData  = 16'h7FFF;
        @(negedge clk);
      end
    end
    inValid = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  // pat 0: full-range random, 1: constant val, 2: random within +-val
  task automatic makeInput(input int n, input int pat, input int val);
    for (int i = 0; i < n; i++) begin
      if (pat == 0)      xs[i] = (nextRand() % 65536) - 32768;
      else if (pat == 1) xs[i] = val;
      else               xs[i] = (nextRand() % (2 * val + 1)) - val;
    end
  endtask

  // Configure, start, stream, then compare against the integer CIC model
  task automatic runCase(input string req, input int stg, input int rate, input int grow,
                         input bit byp, input int n, input bit gaps);
    int nEff, dEff, gEff, k, idx;
    cfgStages = 3'(stg);
    cfgRate   = 10'(rate);
    cfgGrowth = 6'(grow);
    cfgBypass = byp;
    doReset();
    pulseStart();
    feed(n, gaps);
    nEff = byp ? 0 : ((stg > 5) ? 5 : stg);
    dEff = byp ? 1 : rate + 1;
    gEff = byp ? 0 : grow;
    for (int i = 0; i < n; i++) acc[i] = longint'(xs[i]);
    for (int s = 0; s < nEff; s++)
      for (int i = 1; i < n; i++) acc[i] = acc[i] + acc[i-1];
    k = n / dEff;
    for (int j = 0; j < k; j++) begin
      idx = j * dEff + dEff - 6;
      dk[j] = (idx >= 0) ? acc[idx] : 0;
    end
    for (int s = 0; s < nEff; s++)
      for (int j = k - 1; j >= 1; j--) dk[j] = dk[j] - dk[j-1];
    check({req, " output count"}, nGot, k);
    for (int j = 0; j < k && j < nGot; j++)
      check(req, longint'($signed(got[j])), roundModel(dk[j], gEff));
  endtask

  task automatic testResetState();
    cfgStages = 3'd2; cfgRate = 10'd1; cfgGrowth = 6'd2; cfgBypass = 1'b0;
    doReset();
    check("R1 outValid after reset", outValid, 0);
    check("R1 outData after reset", outData, 0);
    makeInput(20, 0, 0);
    feed(20, 1'b0);
    check("R1 no output without start", nGot, 0);
  endtask

  task automatic testPrestartIgnored();
    cfgStages = 3'd2; cfgRate = 10'd3; cfgGrowth = 6'd4; cfgBypass = 1'b0;
    doReset();
    makeInput(30, 1, 30000);
    feed(30, 1'b0);
    check("R2 no output before start", nGot, 0);
    pulseStart();
    makeInput(48, 0, 0);
    begin
      // run the model on the post-start samples only
      int dummy;
      dummy = 0;
    end
    feedAndCheckNoReset("R2", 2, 3, 4, 48);
  endtask

  // Same as runCase but continues from the current (already started) state
  task automatic feedAndCheckNoReset(input string req, input int stg, input int rate,
                                     input int grow, input int n);
    int dEff, k, idx;
    feed(n, 1'b0);
    dEff = rate + 1;
    for (int i = 0; i < n; i++) acc[i] = longint'(xs[i]);
    for (int s = 0; s < stg; s++)
      for (int i = 1; i < n; i++) acc[i] = acc[i] + acc[i-1];
    k = n / dEff;
    for (int j = 0; j < k; j++) begin
      idx = j * dEff + dEff - 6;
      dk[j] = (idx >= 0) ? acc[idx] : 0;
    end
    for (int s = 0; s < stg; s++)
      for (int j = k - 1; j >= 1; j--) dk[j] = dk[j] - dk[j-1];
    check({req, " output count"}, nGot, k);
    for (int j = 0; j < k && j < nGot; j++)
      check(req, longint'($signed(got[j])), roundModel(dk[j], grow));
  endtask

  task automatic testOneStage();
    makeInput(80, 0, 0);
    runCase("R3 R4 one stage D4", 1, 3, 2, 1'b0, 80, 1'b0);
  endtask

  task automatic testThreeStage();
    makeInput(100, 0, 0);
    runCase("R4 R6 three stages D5", 3, 4, 7, 1'b0, 100, 1'b0);
  endtask

  task automatic testFiveStage();
    makeInput(160, 0, 0);
    runCase("R4 R6 five stages D8", 5, 7, 15, 1'b0, 160, 1'b0);
    makeInput(160, 1, -32768);
    runCase("R6 five stages full scale", 5, 7, 15, 1'b0, 160, 1'b0);
  endtask

  task automatic testStageCodes();
    makeInput(60, 0, 0);
    runCase("R5 stage code 7 acts as 5", 7, 1, 5, 1'b0, 60, 1'b0);
    makeInput(60, 0, 0);
    runCase("R5 stage code 0 plain decimator", 0, 2, 0, 1'b0, 60, 1'b0);
  endtask

  task automatic testRounding();
    makeInput(80, 2, 5);
    runCase("R7 symmetric rounding", 1, 1, 5, 1'b0, 80, 1'b0);
    makeInput(40, 1, 3);
    runCase("R7 tie positive", 1, 1, 5, 1'b0, 40, 1'b0);
    check("R7 tie 6/32 rounds up to 2", longint'($signed(got[10])), 2);
    makeInput(40, 1, -3);
    runCase("R7 tie negative", 1, 1, 5, 1'b0, 40, 1'b0);
    check("R7 tie -6/32 rounds to -2", longint'($signed(got[10])), -2);
  endtask

  task automatic testSaturation();
    makeInput(264, 1, 31775);
    runCase("R8 positive clamp", 1, 32, 5, 1'b0, 264, 1'b0);
    check("R8 clamp to 0x3FFFF", longint'(got[5]), 262143);
    makeInput(264, 1, -31775);
    runCase("R8 negative edge", 1, 32, 5, 1'b0, 264, 1'b0);
    check("R8 lands on -262144", longint'($signed(got[5])), -262144);
  endtask

  task automatic testBypass();
    makeInput(40, 0, 0);
    runCase("R9 bypass", 3, 7, 10, 1'b1, 40, 1'b0);
    check("R9 first outputs are zero", longint'($signed(got[0])), 0);
  endtask

  task automatic testGaps();
    makeInput(60, 0, 0);
    runCase("R10 gapped input", 2, 2, 4, 1'b0, 60, 1'b1);
    check("R10 no back-to-back strobes", backToBack, 0);
  endtask

  task automatic testMidReset();
    cfgStages = 3'd3; cfgRate = 10'd3; cfgGrowth = 6'd6; cfgBypass = 1'b0;
    doReset();
    pulseStart();
    makeInput(40, 1, 20000);
    feed(40, 1'b0);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R11 outData cleared by reset", outData, 0);
    @(negedge clk);
    rstN = 1'b1;
    nGot = 0;
    makeInput(30, 0, 0);
    feed(30, 1'b0);
    check("R11 halted until restart", nGot, 0);
    pulseStart();
    makeInput(64, 0, 0);
    feedAndCheckNoReset("R11 restart from clear state", 3, 3, 6, 64);
  endtask

  initial begin
    testResetState();
    testPrestartIgnored();
    testOneStage();
    testThreeStage();
    testFiveStage();
    testStageCodes();
    testRounding();
    testSaturation();
    testBypass();
    testGaps();
    testMidReset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule